// File: doc/BRIEF.md
# Time-of-Day Counter and Interval Timer

This block sits in a processor's bus register area. It holds a 64-bit counter that advances on every enabled tick from reset, a 32-bit interval timer that counts down on the same tick, and two constant information words: ticks per microsecond and, optionally, the RAM size. Software reads the 64-bit count as two 32-bit words.

Reading the low word also copies the upper half of the count into a shadow register. A later read of the high word returns that shadow, so the pair always describes one instant, even when a carry crosses the word boundary between the two reads.

When the timer is at zero and a tick arrives, it wraps to all ones and raises a level interrupt. The interrupt stays high until software writes the timer. Each bus transaction lasts one cycle, and read data appears on the cycle after the request.

Top module: `tod_timer_regs`

## Requirements
- R1: While `rst` is high and after reset, the count equals parameter `TOD_INIT` (default 0), the shadow and `bus_rdata` are 0, the timer is 0xFFFFFFFF and `timer_irq` is 0.
- R2: The 64-bit count rises by exactly one on every clock with `tick_en` high and holds when `tick_en` is low; a carry propagates from bit 31 into bit 32.
- R3: A read of word index 0 returns, one cycle later, bits 31:0 of the count as they were at the request edge.
- R4: A read of word index 0 captures bits 63:32 of the count at that edge into a shadow; a read of word index 1 returns the shadow and never the live high word.
- R5: The timer (word index 2) drops by one on every clock with `tick_en` high and holds otherwise; a read returns its value at the request edge.
- R6: A tick while the timer is 0 sets it to 0xFFFFFFFF and sets `timer_irq`, which remains high until a timer write.
- R7: A write to word index 2 loads `bus_wdata` into the timer and clears `timer_irq`; in a cycle where the write and a tick coincide, the write wins.
- R8: A read of word index 3 returns parameter `TICKS_PER_US`.
- R9: Writes to word indices 0, 1, 3 and 4 change neither the count, the shadow nor any read value.
- R10: With `HAS_RAMSIZE`=1, a read of word index 4 returns `RAM_BYTES`; indices 5 to 7, and index 4 when `HAS_RAMSIZE`=0, read as 0.
- R11: `bus_rdata` holds its last value in every cycle without a read request (`bus_sel` low, or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle tick strobe for the counter and timer |
| bus_sel | input | 1 | Bus transaction request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| timer_irq | output | 1 | Level interrupt raised when the timer wraps |

## Verification
The hardest case to reach is the carry from the low word into the high word, with low/high read pairs placed on both sides of it. Reaching it by ticking from zero would take about four billion cycles. The bench therefore builds the block with `TOD_INIT` set sixteen ticks below the boundary. It then interleaves low and high reads with ticks, so that one pair straddles the carry. Timer wrap is reached by writing small values. A write is also made to coincide with a tick at zero.

// File: rtl/tod_timer_pkg.sv
package tod_timer_pkg;

    localparam int DW = 32;
    localparam int AW = 3;
    localparam int CNT_W = 2 * DW;

    typedef enum logic [AW-1:0] {
        RI_TOD_LO = 3'd0,
        RI_TOD_HI = 3'd1,
        RI_TIMER  = 3'd2,
        RI_SCALE  = 3'd3,
        RI_RAMSZ  = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic          sel;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic          rd;
        logic          snap;
        logic          wr_timer;
        logic [AW-1:0] idx;
    } bus_dec_t;

    function automatic bus_dec_t decode(bus_req_t r);
        bus_dec_t d;
        d.rd       = r.sel && !r.wr;
        d.snap     = d.rd && (r.addr == RI_TOD_LO);
        d.wr_timer = r.sel && r.wr && (r.addr == RI_TIMER);
        d.idx      = r.addr;
        return d;
    endfunction

endpackage

// File: rtl/tod_counter.sv
module tod_counter
    import tod_timer_pkg::*;
#(
    parameter logic [CNT_W-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             snap,
    output logic [CNT_W-1:0] count_o,
    output logic [DW-1:0]    shadow_o
);
    logic [CNT_W-1:0] count_q;
    logic [DW-1:0]    shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= INIT;
            shadow_q <= '0;
        end else begin
            if (tick_en) count_q <= count_q + 1'b1;
            if (snap)    shadow_q <= count_q[CNT_W-1:DW];
        end
    end

    assign count_o  = count_q;
    assign shadow_o = shadow_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tod_timer_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] value_o,
    output logic          irq_o
);
    logic [DW-1:0] val_q;
    logic          irq_q;
    logic          wrap;

    assign wrap = tick_en && (val_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '1;
            irq_q <= 1'b0;
        end else if (load) begin
            val_q <= load_val;
            irq_q <= 1'b0;
        end else begin
            if (tick_en) val_q <= val_q - 1'b1;
            if (wrap)    irq_q <= 1'b1;
        end
    end

    assign value_o = val_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/tod_read_mux.sv
module tod_read_mux
    import tod_timer_pkg::*;
#(
    parameter logic [DW-1:0] TICKS_PER_US = 32'd200,
    parameter bit            HAS_RAMSIZE  = 1'b1,
    parameter logic [DW-1:0] RAM_BYTES    = 32'h0010_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_dec_t      dec,
    input  logic [DW-1:0] tod_lo,
    input  logic [DW-1:0] tod_hi_shadow,
    input  logic [DW-1:0] timer_val,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] ramsz_word;
    logic [DW-1:0] rd_next;
    logic [DW-1:0] rdata_q;

    generate
        if (HAS_RAMSIZE) begin : g_ramsz
            assign ramsz_word = RAM_BYTES;
        end else begin : g_no_ramsz
            assign ramsz_word = '0;
        end
    endgenerate

    always_comb begin
        case (dec.idx)
            RI_TOD_LO: rd_next = tod_lo;
            RI_TOD_HI: rd_next = tod_hi_shadow;
            RI_TIMER:  rd_next = timer_val;
            RI_SCALE:  rd_next = TICKS_PER_US;
            RI_RAMSZ:  rd_next = ramsz_word;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (dec.rd) rdata_q <= rd_next;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/tod_timer_regs.sv
module tod_timer_regs
    import tod_timer_pkg::*;
#(
    parameter logic [DW-1:0]    TICKS_PER_US = 32'd200,
    parameter bit               HAS_RAMSIZE  = 1'b1,
    parameter logic [DW-1:0]    RAM_BYTES    = 32'h0010_0000,
    parameter logic [CNT_W-1:0] TOD_INIT     = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          timer_irq
);
    bus_req_t         req;
    bus_dec_t         dec;
    logic [CNT_W-1:0] tod_count;
    logic [DW-1:0]    tod_shadow;
    logic [DW-1:0]    timer_val;

    assign req.sel   = bus_sel;
    assign req.wr    = bus_wr;
    assign req.addr  = bus_addr;
    assign req.wdata = bus_wdata;
    assign dec       = decode(req);

    tod_counter #(.INIT(TOD_INIT)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .snap     (dec.snap),
        .count_o  (tod_count),
        .shadow_o (tod_shadow)
    );

    interval_timer u_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load     (dec.wr_timer),
        .load_val (req.wdata),
        .value_o  (timer_val),
        .irq_o    (timer_irq)
    );

    tod_read_mux #(
        .TICKS_PER_US (TICKS_PER_US),
        .HAS_RAMSIZE  (HAS_RAMSIZE),
        .RAM_BYTES    (RAM_BYTES)
    ) u_rmux (
        .clk           (clk),
        .rst           (rst),
        .dec           (dec),
        .tod_lo        (tod_count[DW-1:0]),
        .tod_hi_shadow (tod_shadow),
        .timer_val     (timer_val),
        .rdata_o       (bus_rdata)
    );
endmodule

// File: rtl/tod_timer_chk.sv
module tod_timer_chk
    import tod_timer_pkg::*;
#(
    parameter logic [DW-1:0] TICKS_PER_US = 32'd200
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    bus_rdata,
    input logic             timer_irq,
    input logic [CNT_W-1:0] count,
    input logic [DW-1:0]    timer
);
    logic wr_tmr;
    assign wr_tmr = bus_sel && bus_wr && (bus_addr == RI_TIMER);

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> count == $past(count) + 1'b1);

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(count));

    p_tmr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_tmr) |=> timer == $past(timer) - 1'b1);

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_tmr && timer == '0) |=> (timer == '1) && timer_irq);

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (timer_irq && !wr_tmr) |=> timer_irq);

    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        wr_tmr |=> (timer == $past(bus_wdata)) && !timer_irq);

    p_scale_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == RI_SCALE) |=> bus_rdata == TICKS_PER_US);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind tod_timer_regs tod_timer_chk #(.TICKS_PER_US(TICKS_PER_US)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .timer_irq (timer_irq),
    .count     (tod_count),
    .timer     (timer_val)
);

// File: tb/test_tod_timer_regs.sv
`timescale 1ns/1ps
module test_tod_timer_regs;

    localparam logic [31:0] SCALE = 32'd200;
    localparam logic [31:0] RAMSZ = 32'h0010_0000;
    localparam logic [63:0] INITV = 64'h0000_0000_FFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        timer_irq;

    always #2.5 clk = ~clk;

    tod_timer_regs #(
        .TICKS_PER_US (SCALE),
        .HAS_RAMSIZE  (1'b1),
        .RAM_BYTES    (RAMSZ),
        .TOD_INIT     (INITV)
    ) i_tod_timer_regs (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .timer_irq (timer_irq)
    );

    // behavioural reference model
    logic [63:0] m_cnt    = INITV;
    logic [31:0] m_shadow = '0;
    logic [31:0] m_timer  = 32'hFFFF_FFFF;
    logic        m_irq    = 1'b0;
    logic [31:0] m_rdata  = '0;
    bit          started  = 1'b0;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_cnt = INITV; m_shadow = '0; m_timer = 32'hFFFF_FFFF;
            m_irq = 1'b0; m_rdata = '0;
        end else begin
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    3'd0: begin m_rdata = m_cnt[31:0]; m_shadow = m_cnt[63:32]; end
                    3'd1: m_rdata = m_shadow;
                    3'd2: m_rdata = m_timer;
                    3'd3: m_rdata = SCALE;
                    3'd4: m_rdata = RAMSZ;
                    default: m_rdata = '0;
                endcase
            end
            if (bus_sel && bus_wr && bus_addr == 3'd2) begin
                m_timer = bus_wdata; m_irq = 1'b0;
            end else if (tick_en) begin
                if (m_timer == 0) m_irq = 1'b1;
                m_timer = m_timer - 1;
            end
            if (tick_en) m_cnt = m_cnt + 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            if (bus_rdata !== m_rdata || timer_irq !== m_irq) begin
                miscompares++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         cur_req, bus_rdata, timer_irq, m_rdata, m_irq);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n, input bit tk);
        for (int i = 0; i < n; i++) begin
            bus_sel = 0; bus_wr = 0; tick_en = tk;
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [2:0] a, input bit tk, output logic [31:0] v);
        bus_sel = 1; bus_wr = 0; bus_addr = a; tick_en = tk;
        @(negedge clk);
        bus_sel = 0; tick_en = 0;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit tk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; tick_en = 0;
    endtask

    logic [31:0] v, lo, hi;

    initial begin
        @(negedge clk);
        @(negedge clk);
        cur_req = "R1";
        check("R1", bus_rdata, 32'h0);
        check("R1", {31'b0, timer_irq}, 32'h0);
        rst = 0;
        rd(3'd0, 0, v); check("R1", v, INITV[31:0]);
        rd(3'd1, 0, v); check("R4", v, INITV[63:32]);
        rd(3'd2, 0, v); check("R1", v, 32'hFFFF_FFFF);

        cur_req = "R2";
        idle(5, 1);
        idle(3, 0);
        rd(3'd0, 0, v); check("R2", v, 32'hFFFF_FFF5);

        // straddle the low-to-high carry
        cur_req = "R4";
        rd(3'd0, 1, lo);
        idle(12, 1);
        rd(3'd1, 0, hi);
        check("R3", lo, 32'hFFFF_FFF5);
        check("R4", hi, 32'h0);
        rd(3'd0, 0, lo); rd(3'd1, 0, hi);
        check("R2", lo, 32'h0000_0002);
        check("R4", hi, 32'h1);

        cur_req = "R5";
        rd(3'd2, 0, v); check("R5", v, 32'hFFFF_FFFF - 18);

        cur_req = "R6";
        wr(3'd2, 32'd3, 0);
        idle(3, 1);
        check("R6", {31'b0, timer_irq}, 32'h0);
        idle(1, 1);
        check("R6", {31'b0, timer_irq}, 32'h1);
        idle(4, 0);
        check("R6", {31'b0, timer_irq}, 32'h1);
        rd(3'd2, 0, v); check("R6", v, 32'hFFFF_FFFF);

        cur_req = "R7";
        wr(3'd2, 32'd0, 0);
        check("R7", {31'b0, timer_irq}, 32'h0);
        wr(3'd2, 32'd9, 1);
        rd(3'd2, 0, v); check("R7", v, 32'd9);
        wr(3'd2, 32'd0, 0);
        idle(1, 1);
        check("R6", {31'b0, timer_irq}, 32'h1);
        wr(3'd2, 32'd0, 1);
        check("R7", {31'b0, timer_irq}, 32'h0);

        cur_req = "R8";
        rd(3'd3, 0, v); check("R8", v, SCALE);
        cur_req = "R10";
        rd(3'd4, 0, v); check("R10", v, RAMSZ);
        rd(3'd5, 0, v); check("R10", v, 32'h0);
        rd(3'd7, 0, v); check("R10", v, 32'h0);

        cur_req = "R9";
        rd(3'd0, 0, lo);
        wr(3'd0, 32'h1234_5678, 0);
        wr(3'd1, 32'hDEAD_BEEF, 0);
        wr(3'd3, 32'h5, 0);
        wr(3'd4, 32'h7, 0);
        rd(3'd1, 0, v); check("R9", v, 32'h1);
        rd(3'd0, 0, v); check("R9", v, lo);
        rd(3'd3, 0, v); check("R9", v, SCALE);
        rd(3'd4, 0, v); check("R9", v, RAMSZ);

        cur_req = "R11";
        rd(3'd3, 0, v);
        wr(3'd2, 32'h40, 1);
        idle(3, 1);
        check("R11", bus_rdata, SCALE);

        cur_req = "mixed traffic R2 R5 R6 R7";
        for (int i = 0; i < 400; i++) begin
            bus_sel   = ($urandom % 3) != 0;
            bus_wr    = ($urandom % 3) == 0;
            bus_addr  = 3'($urandom % 8);
            bus_wdata = (($urandom % 2) == 0) ? 32'($urandom % 6) : $urandom;
            tick_en   = ($urandom % 4) != 0;
            @(negedge clk);
        end
        bus_sel = 0; tick_en = 0;
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule